// File: doc/BRIEF.md
# Three-hop home-node read coherence controller

This block is the home agent for lines whose backing memory sits at this node, in a small multiprocessor model that has no directory. A read request from some node arrives on the request port. The home controller then does two things at once. It sends a snoop to every other caching node, one valid bit per node, and it launches a read of the line from local memory. When the memory word returns, the home node sends it toward the requester on a forward port. The peers answer their snoops directly to the requester, not to the home node.

A requester-side collector is also part of the block. It tallies the peer answers and the forwarded memory beat. It releases the line only when every peer has answered and the memory word has arrived, which covers all three message legs and the memory read. If a peer reports that it holds a modified copy, the data from that peer is delivered in place of the memory word. The controller handles one transaction at a time. It stays busy until the line has been handed over.

Top module: `hop3_home_ctrl`

## Requirements
- R1: While idle, `req_ready` is 1. When `req_valid` is sampled high with `req_ready` high, `mem_rd_valid` is 1 for exactly one cycle in the next cycle. In that same cycle, `mem_rd_addr` and `snp_addr` equal the accepted `req_addr`.
- R2: In that same issue cycle, `snp_valid` has bit i set for every node i except the requester `req_node`, which gives NODES-1 bits. Outside the issue cycle, `snp_valid` is zero.
- R3: The first `mem_rsp_valid` sampled after acceptance makes `fwd_valid` 1 for exactly one cycle in the next cycle, with `fwd_data` equal to the sampled `mem_rsp_data`.
- R4: `data_ready` pulses for one cycle. The pulse comes in the cycle after the clock edge on which both conditions first hold together: NODES-1 peer responses have been counted, and the forward beat (`fwd_valid`) has been sampled. The pulse never comes earlier.
- R5: Some responses may have `rsp_modified` set. When they do, `data_out` carries the `rsp_data` slice (bits [i*DW +: DW] for node i) of the first such response to arrive, and `data_from_peer` is 1. Among modified responses that arrive in the same cycle, the lowest node index wins. With no modified response, `data_out` is the memory word and `data_from_peer` is 0.
- R6: From acceptance until the `data_ready` pulse, `req_ready` is 0, and any `req_valid` is ignored: no snoop and no memory read are issued.
- R7: `req_ready` returns to 1 in the cycle after the `data_ready` pulse.
- R8: `rsp_valid` and `mem_rsp_valid` are ignored while idle, and they do not count toward the next transaction.
- R9: A synchronous active-low `rst_n` returns the block to idle (`req_ready`=1, every valid output 0). It also clears all response and memory counts, so a transaction that was cut off leaves nothing behind.
- R10: A response bit at the requester's own index in `rsp_valid` is ignored. It does not count, and its modified flag and data are not used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_node | input | IDW | Requesting node index |
| req_addr | input | AW | Line address of the request |
| snp_valid | output | NODES | One snoop valid bit per node, requester excluded |
| snp_addr | output | AW | Address carried by the snoops |
| mem_rd_valid | output | 1 | Local memory read launch |
| mem_rd_addr | output | AW | Memory read address |
| mem_rsp_valid | input | 1 | Memory read data valid |
| mem_rsp_data | input | DW | Memory read data |
| fwd_valid | output | 1 | Memory word forwarded to the requester |
| fwd_data | output | DW | Forwarded memory word |
| rsp_valid | input | NODES | Snoop response valid, one bit per answering node |
| rsp_modified | input | NODES | Answering node held a modified copy |
| rsp_data | input | NODES*DW | Line data supplied by each answering node |
| data_ready | output | 1 | One-cycle pulse: line may be consumed |
| data_out | output | DW | Delivered line data |
| data_from_peer | output | 1 | Delivered data came from a modified peer copy |

## Verification
Some properties are checked by the assertions on every cycle. Each acceptance must be followed by a single memory read and snoop burst that carries the accepted address. The snoop vector must have exactly NODES-1 bits and must exclude the latched requester. Every forward must follow a memory response. Each delivery pulse must be preceded by a full set of counted responses plus a forward, and it must be followed by `req_ready` returning. Other behaviour can only be shown by the bench scenarios, which compare a behavioural model on every clock:
- which modified peer wins when arrivals are ordered in time or tie in the same cycle,
- that stray responses while idle and the requester's own response bit are ignored,
- that requests made while busy are ignored,
- that a reset mid-transaction leaves no partial counts.

// File: rtl/hop3_pkg.sv
package hop3_pkg;

  typedef enum logic [1:0] {
    H_IDLE      = 2'd0,
    H_SNOOP     = 2'd1,
    H_WAIT_MEM  = 2'd2,
    H_WAIT_DONE = 2'd3
  } home_st_e;

  localparam int unsigned MAX_NODES = 32;

  // Population count of a node vector, zero-extended to MAX_NODES bits.
  function automatic int unsigned count_bits(input logic [MAX_NODES-1:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < MAX_NODES; i++) begin
      if (v[i]) n++;
    end
    return n;
  endfunction

endpackage

// File: rtl/home_engine.sv
module home_engine
  import hop3_pkg::*;
#(
  parameter int unsigned IDW = 2,
  parameter int unsigned AW  = 16,
  parameter int unsigned DW  = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  input  logic [IDW-1:0] req_node,
  input  logic [AW-1:0]  req_addr,
  input  logic           mem_rsp_valid,
  input  logic [DW-1:0]  mem_rsp_data,
  input  logic           deliver,
  output logic           req_ready,
  output logic           issue,
  output logic           busy,
  output logic [IDW-1:0] cur_node,
  output logic [AW-1:0]  cur_addr,
  output logic           fwd_valid,
  output logic [DW-1:0]  fwd_data
);

  home_st_e state;

  assign req_ready = (state == H_IDLE);
  assign issue     = (state == H_SNOOP);
  assign busy      = (state != H_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= H_IDLE;
      cur_node  <= '0;
      cur_addr  <= '0;
      fwd_valid <= 1'b0;
      fwd_data  <= '0;
    end else begin
      fwd_valid <= 1'b0;
      case (state)
        H_IDLE: begin
          if (req_valid) begin
            cur_node <= req_node;
            cur_addr <= req_addr;
            state    <= H_SNOOP;
          end
        end
        H_SNOOP, H_WAIT_MEM: begin
          if (mem_rsp_valid) begin
            fwd_valid <= 1'b1;
            fwd_data  <= mem_rsp_data;
            state     <= H_WAIT_DONE;
          end else begin
            state <= H_WAIT_MEM;
          end
        end
        H_WAIT_DONE: begin
          if (deliver) state <= H_IDLE;
        end
        default: state <= H_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/snoop_fanout.sv
module snoop_fanout #(
  parameter int unsigned NODES = 4,
  parameter int unsigned IDW   = 2
) (
  input  logic             issue,
  input  logic [IDW-1:0]   node,
  output logic [NODES-1:0] peer_mask,
  output logic [NODES-1:0] snp_valid
);

  for (genvar g = 0; g < NODES; g++) begin : g_peer
    localparam logic [IDW-1:0] ID = IDW'(g);
    assign peer_mask[g] = (node != ID);
    assign snp_valid[g] = issue & peer_mask[g];
  end

endmodule

// File: rtl/resp_collector.sv
module resp_collector
  import hop3_pkg::*;
#(
  parameter int unsigned NODES = 4,
  parameter int unsigned DW    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                armed,
  input  logic [NODES-1:0]    expect_mask,
  input  logic [NODES-1:0]    rsp_valid,
  input  logic [NODES-1:0]    rsp_modified,
  input  logic [NODES*DW-1:0] rsp_data,
  input  logic                fwd_valid,
  input  logic [DW-1:0]       fwd_data,
  output logic                data_ready,
  output logic [DW-1:0]       data_out,
  output logic                data_from_peer
);

  localparam int unsigned CW    = $clog2(NODES + 1) + 1;
  localparam logic [CW-1:0] NEED = CW'(NODES - 1);

  logic [CW-1:0]    cnt_q, cnt_n;
  logic             mem_seen_q, mem_seen_n;
  logic [DW-1:0]    mem_q, mem_n;
  logic             dirty_q, dirty_n;
  logic [DW-1:0]    dirty_data_q, dirty_data_n;
  logic [NODES-1:0] hits;
  logic             pick;
  logic [DW-1:0]    pick_data;
  logic             fire;

  assign hits = rsp_valid & expect_mask & {NODES{armed}};

  // Lowest-index modified responder of this cycle.
  always_comb begin
    pick      = 1'b0;
    pick_data = '0;
    for (int i = NODES - 1; i >= 0; i--) begin
      if (hits[i] && rsp_modified[i]) begin
        pick      = 1'b1;
        pick_data = rsp_data[i*DW +: DW];
      end
    end
  end

  always_comb begin
    cnt_n        = cnt_q + CW'(count_bits(MAX_NODES'(hits)));
    mem_seen_n   = mem_seen_q | (armed & fwd_valid);
    mem_n        = (armed & fwd_valid) ? fwd_data : mem_q;
    dirty_n      = dirty_q | pick;
    dirty_data_n = dirty_q ? dirty_data_q : pick_data;
    fire         = armed && mem_seen_n && (cnt_n == NEED);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q          <= '0;
      mem_seen_q     <= 1'b0;
      mem_q          <= '0;
      dirty_q        <= 1'b0;
      dirty_data_q   <= '0;
      data_ready     <= 1'b0;
      data_out       <= '0;
      data_from_peer <= 1'b0;
    end else begin
      data_ready <= fire;
      if (fire) begin
        data_out       <= dirty_n ? dirty_data_n : mem_n;
        data_from_peer <= dirty_n;
      end
      if (fire || !armed) begin
        cnt_q        <= '0;
        mem_seen_q   <= 1'b0;
        dirty_q      <= 1'b0;
      end else begin
        cnt_q        <= cnt_n;
        mem_seen_q   <= mem_seen_n;
        mem_q        <= mem_n;
        dirty_q      <= dirty_n;
        dirty_data_q <= dirty_data_n;
      end
    end
  end

endmodule

// File: rtl/hop3_home_ctrl.sv
module hop3_home_ctrl #(
  parameter int unsigned NODES = 4,
  parameter int unsigned AW    = 16,
  parameter int unsigned DW    = 32,
  parameter int unsigned IDW   = (NODES > 1) ? $clog2(NODES) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic [IDW-1:0]      req_node,
  input  logic [AW-1:0]       req_addr,
  output logic [NODES-1:0]    snp_valid,
  output logic [AW-1:0]       snp_addr,
  output logic                mem_rd_valid,
  output logic [AW-1:0]       mem_rd_addr,
  input  logic                mem_rsp_valid,
  input  logic [DW-1:0]       mem_rsp_data,
  output logic                fwd_valid,
  output logic [DW-1:0]       fwd_data,
  input  logic [NODES-1:0]    rsp_valid,
  input  logic [NODES-1:0]    rsp_modified,
  input  logic [NODES*DW-1:0] rsp_data,
  output logic                data_ready,
  output logic [DW-1:0]       data_out,
  output logic                data_from_peer
);

  logic             issue;
  logic             busy;
  logic [IDW-1:0]   cur_node;
  logic [AW-1:0]    cur_addr;
  logic [NODES-1:0] peer_mask;

  // Named events for the bound checker.
  logic accept_evt;
  logic deliver_evt;
  assign accept_evt  = req_valid & req_ready;
  assign deliver_evt = data_ready;

  home_engine #(.IDW(IDW), .AW(AW), .DW(DW)) u_home (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_node      (req_node),
    .req_addr      (req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_data  (mem_rsp_data),
    .deliver       (deliver_evt),
    .req_ready     (req_ready),
    .issue         (issue),
    .busy          (busy),
    .cur_node      (cur_node),
    .cur_addr      (cur_addr),
    .fwd_valid     (fwd_valid),
    .fwd_data      (fwd_data)
  );

  snoop_fanout #(.NODES(NODES), .IDW(IDW)) u_fan (
    .issue     (issue),
    .node      (cur_node),
    .peer_mask (peer_mask),
    .snp_valid (snp_valid)
  );

  assign snp_addr     = cur_addr;
  assign mem_rd_valid = issue;
  assign mem_rd_addr  = cur_addr;

  resp_collector #(.NODES(NODES), .DW(DW)) u_coll (
    .clk            (clk),
    .rst_n          (rst_n),
    .armed          (busy),
    .expect_mask    (peer_mask),
    .rsp_valid      (rsp_valid),
    .rsp_modified   (rsp_modified),
    .rsp_data       (rsp_data),
    .fwd_valid      (fwd_valid),
    .fwd_data       (fwd_data),
    .data_ready     (data_ready),
    .data_out       (data_out),
    .data_from_peer (data_from_peer)
  );

endmodule

// File: rtl/hop3_home_chk.sv
module hop3_home_chk #(
  parameter int unsigned NODES = 4,
  parameter int unsigned AW    = 16,
  parameter int unsigned IDW   = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic [IDW-1:0]   req_node,
  input logic [AW-1:0]    req_addr,
  input logic [NODES-1:0] snp_valid,
  input logic [AW-1:0]    snp_addr,
  input logic             mem_rd_valid,
  input logic [AW-1:0]    mem_rd_addr,
  input logic             mem_rsp_valid,
  input logic             fwd_valid,
  input logic [NODES-1:0] rsp_valid,
  input logic             data_ready,
  input logic             accept_evt
);

  logic           c_busy;
  logic [IDW-1:0] c_node;
  int unsigned    c_rsp;
  logic           c_fwd;
  logic [NODES-1:0] own_bit;

  assign own_bit = NODES'(1) << c_node;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_busy <= 1'b0;
      c_node <= '0;
      c_rsp  <= 0;
      c_fwd  <= 1'b0;
    end else if (accept_evt) begin
      c_busy <= 1'b1;
      c_node <= req_node;
      c_rsp  <= 0;
      c_fwd  <= 1'b0;
    end else if (c_busy) begin
      c_rsp <= c_rsp + $countones(rsp_valid & ~own_bit);
      if (fwd_valid) c_fwd <= 1'b1;
      if (data_ready) c_busy <= 1'b0;
    end
  end

  // R1
  acc_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> (mem_rd_valid && mem_rd_addr == $past(req_addr) && snp_addr == $past(req_addr)));

  // R1
  issue_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |=> !mem_rd_valid);

  // R2
  snoop_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid != '0) |-> ($countones(snp_valid) == NODES - 1 && !snp_valid[c_node] && mem_rd_valid));

  // R3
  fwd_after_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_valid |-> $past(mem_rsp_valid));

  // R4
  deliver_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_ready |-> (c_rsp == NODES - 1 && c_fwd));

  // R4
  deliver_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_ready |=> !data_ready);

  // R6
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> !req_ready);

  // R7
  idle_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_ready |=> req_ready);

endmodule

bind hop3_home_ctrl hop3_home_chk #(.NODES(NODES), .AW(AW), .IDW(IDW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_ready     (req_ready),
  .req_node      (req_node),
  .req_addr      (req_addr),
  .snp_valid     (snp_valid),
  .snp_addr      (snp_addr),
  .mem_rd_valid  (mem_rd_valid),
  .mem_rd_addr   (mem_rd_addr),
  .mem_rsp_valid (mem_rsp_valid),
  .fwd_valid     (fwd_valid),
  .rsp_valid     (rsp_valid),
  .data_ready    (data_ready),
  .accept_evt    (accept_evt)
);

// File: tb/hop3_home_ctrl_tb.sv
module hop3_home_ctrl_tb;

  localparam int NODES = 4;
  localparam int AW    = 16;
  localparam int DW    = 32;
  localparam int IDW   = 2;

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic                req_valid = 1'b0;
  logic                req_ready;
  logic [IDW-1:0]      req_node = '0;
  logic [AW-1:0]       req_addr = '0;
  logic [NODES-1:0]    snp_valid;
  logic [AW-1:0]       snp_addr;
  logic                mem_rd_valid;
  logic [AW-1:0]       mem_rd_addr;
  logic                mem_rsp_valid = 1'b0;
  logic [DW-1:0]       mem_rsp_data = '0;
  logic                fwd_valid;
  logic [DW-1:0]       fwd_data;
  logic [NODES-1:0]    rsp_valid = '0;
  logic [NODES-1:0]    rsp_modified = '0;
  logic [NODES*DW-1:0] rsp_data = '0;
  logic                data_ready;
  logic [DW-1:0]       data_out;
  logic                data_from_peer;

  always #2.5 clk = ~clk;

  hop3_home_ctrl #(.NODES(NODES), .AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_node(req_node), .req_addr(req_addr), .snp_valid(snp_valid),
    .snp_addr(snp_addr), .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .fwd_valid(fwd_valid), .fwd_data(fwd_data), .rsp_valid(rsp_valid),
    .rsp_modified(rsp_modified), .rsp_data(rsp_data), .data_ready(data_ready),
    .data_out(data_out), .data_from_peer(data_from_peer)
  );

  // ---------------- reference model (updated at each rising edge) ----------
  bit          started = 0;
  bit          m_busy = 0, m_memwait = 0, m_memseen = 0, m_dirty = 0;
  int          m_node = 0, m_cnt = 0;
  logic [AW-1:0] m_addr = '0;
  logic [DW-1:0] m_mdata = '0, m_ddata = '0;
  logic [NODES-1:0] e_snp = '0;
  bit          e_ready = 1, e_mrd = 0, e_fwd = 0, e_dready = 0, e_peer = 0;
  logic [DW-1:0] e_fwd_data = '0, e_dout = '0;

  always @(posedge clk) begin
    bit p_fwd, p_dready;
    logic [DW-1:0] p_fwd_data;
    p_fwd = e_fwd; p_fwd_data = e_fwd_data; p_dready = e_dready;
    e_snp = '0; e_mrd = 0; e_fwd = 0; e_dready = 0;
    started = 1;
    if (!rst_n) begin
      m_busy = 0; m_memwait = 0; m_memseen = 0; m_dirty = 0; m_cnt = 0;
    end else if (!m_busy) begin
      if (req_valid) begin
        m_busy = 1; m_node = int'(req_node); m_addr = req_addr;
        m_memwait = 1; m_cnt = 0; m_memseen = 0; m_dirty = 0;
        for (int p = 0; p < NODES; p++) e_snp[p] = (p != m_node);
        e_mrd = 1;
      end
    end else begin
      if (m_memwait && mem_rsp_valid) begin
        e_fwd = 1; e_fwd_data = mem_rsp_data; m_memwait = 0;
      end
      for (int p = 0; p < NODES; p++) begin
        if (p != m_node && rsp_valid[p]) begin
          m_cnt++;
          if (rsp_modified[p] && !m_dirty) begin
            m_dirty = 1; m_ddata = rsp_data[p*DW +: DW];
          end
        end
      end
      if (p_fwd) begin m_memseen = 1; m_mdata = p_fwd_data; end
      if (p_dready) begin
        m_busy = 0;
      end else if (m_cnt == NODES - 1 && m_memseen) begin
        e_dready = 1; e_peer = m_dirty;
        e_dout = m_dirty ? m_ddata : m_mdata;
        m_cnt = 0; m_memseen = 0; m_dirty = 0;
      end
    end
    e_ready = !m_busy;
  end

  // ---------------- per-cycle comparison (falling edge) --------------------
  int mon_checks = 0, mon_fails = 0;
  int pulses = 0;
  logic [DW-1:0] got_data = '0;
  bit got_peer = 0;

  task automatic mchk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    mon_checks++;
    if (!ok) begin
      mon_fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      mchk(req_ready === e_ready, "R6/R7 req_ready", 64'(req_ready), 64'(e_ready));
      mchk(snp_valid === e_snp, "R2 snp_valid", 64'(snp_valid), 64'(e_snp));
      mchk(mem_rd_valid === e_mrd, "R1 mem_rd_valid", 64'(mem_rd_valid), 64'(e_mrd));
      if (e_mrd) begin
        mchk(mem_rd_addr === m_addr, "R1 mem_rd_addr", 64'(mem_rd_addr), 64'(m_addr));
        mchk(snp_addr === m_addr, "R1 snp_addr", 64'(snp_addr), 64'(m_addr));
      end
      mchk(fwd_valid === e_fwd, "R3 fwd_valid", 64'(fwd_valid), 64'(e_fwd));
      if (e_fwd) mchk(fwd_data === e_fwd_data, "R3 fwd_data", 64'(fwd_data), 64'(e_fwd_data));
      mchk(data_ready === e_dready, "R4 data_ready", 64'(data_ready), 64'(e_dready));
      if (e_dready) begin
        mchk(data_out === e_dout, "R5 data_out", 64'(data_out), 64'(e_dout));
        mchk(data_from_peer === e_peer, "R5 data_from_peer", 64'(data_from_peer), 64'(e_peer));
      end
      if (data_ready === 1'b1) begin
        pulses++; got_data = data_out; got_peer = data_from_peer;
      end
    end
  end

  // ---------------- stimulus and scenario checks ---------------------------
  int t_checks = 0, t_fails = 0;
  int wd_fail = 0;

  task automatic tchk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    t_checks++;
    if (!ok) begin
      t_fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [DW-1:0] peer_word(input int p, input logic [AW-1:0] a);
    return 32'hA000_0000 | (32'(p) << 24) | 32'(a);
  endfunction

  task automatic report();
    int tot, bad;
    tot = mon_checks + t_checks + wd_fail;
    bad = mon_fails + t_fails + wd_fail;
    $display("%0d/%0d checks passed", tot - bad, tot);
  endtask

  task automatic clear_inputs();
    rsp_valid = '0; rsp_modified = '0; mem_rsp_valid = 1'b0;
  endtask

  // node: requester; dly[p]: response cycle of peer p (k>=1); modm: modified peers;
  // hold: cycles after acceptance during which a second request is held;
  // self_rsp: requester also drives its own response bit (modified);
  // abort_k: cycle at which reset is applied (0 = none).
  task automatic run_txn(input int node, input logic [AW-1:0] addr, input int memlat,
                         input int d0, input int d1, input int d2, input int d3,
                         input logic [NODES-1:0] modm, input int hold, input bit self_rsp,
                         input int abort_k, input logic [DW-1:0] exp_data,
                         input bit exp_peer, input string tag);
    int dly[NODES];
    int p0;
    logic [DW-1:0] mword;
    dly[0] = d0; dly[1] = d1; dly[2] = d2; dly[3] = d3;
    mword = 32'h5000_0000 | 32'(addr);
    while (!e_ready) @(negedge clk);
    p0 = pulses;
    req_valid = 1'b1; req_node = IDW'(node); req_addr = addr;
    @(negedge clk);
    for (int k = 1; k <= 40; k++) begin
      if (abort_k != 0 && k == abort_k) begin
        clear_inputs(); req_valid = 1'b0; rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        // R9: synchronous reset leaves the block idle
        tchk(req_ready === 1'b1, "R9 req_ready after reset", 64'(req_ready), 64'd1);
        tchk(data_ready === 1'b0 && fwd_valid === 1'b0 && snp_valid === '0,
             "R9 outputs quiet after reset", 64'(data_ready), 64'd0);
        rst_n = 1'b1;
        return;
      end
      if (k >= 2 && k <= hold)
        tchk(snp_valid === '0 && mem_rd_valid === 1'b0, "R6 no issue while busy",
             64'(snp_valid), 64'd0);
      req_valid = (k < hold);
      req_addr  = (k < hold) ? (addr ^ 16'hFFFF) : addr;
      clear_inputs();
      for (int p = 0; p < NODES; p++) begin
        if (p != node && dly[p] == k) begin
          rsp_valid[p] = 1'b1; rsp_modified[p] = modm[p];
          rsp_data[p*DW +: DW] = peer_word(p, addr);
        end
        if (p == node && self_rsp && k == 1) begin
          rsp_valid[p] = 1'b1; rsp_modified[p] = 1'b1;
          rsp_data[p*DW +: DW] = 32'hDEAD_0000;
        end
      end
      if (k == 1 + memlat) begin mem_rsp_valid = 1'b1; mem_rsp_data = mword; end
      @(negedge clk);
    end
    clear_inputs(); req_valid = 1'b0;
    tchk(pulses - p0 == 1, {tag, " one delivery pulse"}, 64'(pulses - p0), 64'd1);
    tchk(got_data === exp_data, {tag, " delivered data"}, 64'(got_data), 64'(exp_data));
    tchk(got_peer === exp_peer, {tag, " data_from_peer"}, 64'(got_peer), 64'(exp_peer));
    tchk(req_ready === 1'b1, "R7 idle after delivery", 64'(req_ready), 64'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    tchk(req_ready === 1'b1, "R9 reset req_ready", 64'(req_ready), 64'd1);
    tchk(data_ready === 1'b0, "R9 reset data_ready", 64'(data_ready), 64'd0);
    tchk(snp_valid === '0 && mem_rd_valid === 1'b0, "R9 reset snoop idle", 64'(snp_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R3 R4: basic, memory word delivered
    run_txn(0, 16'h0100, 3, 0, 2, 4, 5, 4'b0000, 0, 0, 0, 32'h5000_0100, 0, "R4 basic");
    // R4: all peers early, data waits for memory
    run_txn(2, 16'h0222, 12, 1, 1, 0, 2, 4'b0000, 0, 0, 0, 32'h5000_0222, 0, "R4 mem last");
    // R5: one modified peer
    run_txn(1, 16'h0333, 2, 3, 0, 6, 9, 4'b1000, 0, 0, 0, peer_word(3, 16'h0333), 1, "R5 peer3");
    // R5: two modified in same cycle, lowest index wins
    run_txn(3, 16'h0444, 4, 5, 5, 5, 0, 4'b0101, 0, 0, 0, peer_word(0, 16'h0444), 1, "R5 tie");
    // R5: earlier arrival wins over lower index
    run_txn(0, 16'h0555, 2, 0, 7, 3, 4, 4'b0110, 0, 0, 0, peer_word(2, 16'h0555), 1, "R5 first");
    // R4: last responses and forward beat sampled on the same edge
    run_txn(1, 16'h0666, 2, 4, 0, 4, 4, 4'b0000, 0, 0, 0, 32'h5000_0666, 0, "R4 same edge");
    // R6: second request held while busy is ignored
    run_txn(2, 16'h0777, 8, 2, 3, 0, 4, 4'b0000, 6, 0, 0, 32'h5000_0777, 0, "R6 hold");
    // R10: requester's own modified response ignored
    run_txn(2, 16'h0888, 3, 2, 5, 0, 2, 4'b0000, 0, 1, 0, 32'h5000_0888, 0, "R10 self");

    // R8: stray responses and memory data while idle
    @(negedge clk);
    rsp_valid = '1; rsp_modified = '1; mem_rsp_valid = 1'b1;
    @(negedge clk); @(negedge clk);
    clear_inputs();
    tchk(req_ready === 1'b1 && fwd_valid === 1'b0, "R8 idle stays idle", 64'(req_ready), 64'd1);
    @(negedge clk);
    tchk(data_ready === 1'b0, "R8 no delivery from stray", 64'(data_ready), 64'd0);
    run_txn(3, 16'h0999, 6, 8, 9, 10, 0, 4'b0000, 0, 0, 0, 32'h5000_0999, 0, "R8 after stray");

    // R9: reset in the middle of a transaction, then a clean one
    run_txn(0, 16'h0AAA, 10, 0, 2, 3, 9, 4'b0010, 0, 0, 5, '0, 0, "R9 abort");
    run_txn(0, 16'h0BBB, 3, 0, 6, 6, 7, 4'b0000, 0, 0, 0, 32'h5000_0BBB, 0, "R9 clean after reset");

    repeat (3) @(negedge clk);
    report();
    $finish;
  end

  // watchdog
  int wd_cycles = 0;
  always @(posedge clk) begin
    wd_cycles++;
    if (wd_cycles > 100000) begin
      wd_fail = 1;
      $display("FAIL watchdog: actual %0d cycles expected completion", wd_cycles);
      report();
      $finish;
    end
  end

endmodule